// File: doc/BRIEF.md
# Dual-Port Sample Input Qualifier

This block sits at the head of a multi-channel receive path. Two converter ports feed it. Each port carries a signed mantissa, an unsigned exponent and its own enable pin. Four tuner channels sit downstream. For each channel, a small configuration register picks port A or port B and sets how that port's enable qualifies the samples. The enable can act as a level, as a falling-edge trigger, as a rising-edge trigger, or as a blanking control that zeroes the data while it is low.

Every sample is turned into one 21-bit signed fixed-point word. The 14-bit mantissa goes into the upper bits, and the word is then shifted right arithmetically by the 3-bit exponent, so no exponent value loses range. A converter without an exponent output ties those pins to zero, and the mantissa then appears unchanged in the top bits. Every channel delivers a data word and a one-clock valid strobe.

Top module: `rxfe_dual_port`

## Requirements
- R1: With an exponent of zero, the output word of a valid sample equals the mantissa in bits 20:7, with bits 6:0 zero.
- R2: For exponent e (0 to 7), the output word equals the 21-bit value {mantissa, 7'b0} shifted right arithmetically by e, so the sign is kept.
- R3: Configuration bit 2 selects each channel's source independently: 0 means port A, 1 means port B. The selection covers both the sample and the enable.
- R4: Mode 00 (level, bits 1:0): a sample is valid when the selected enable was high on the clock edge that captured it. Pins sampled at edge k appear on the outputs after edge k+1.
- R5: Mode 01 (falling): valid pulses for one cycle only, for the sample captured on the first edge where the enable reads low after it read high on the previous edge.
- R6: Mode 10 (rising): valid pulses for one cycle only, for the sample captured on the first edge where the enable reads high after it read low on the previous edge.
- R7: Mode 11 (blank): valid is high for every sample, and the data is forced to zero for samples captured while the enable was low.
- R8: When cfg_we is high, cfg_wdata is written into the channel addressed by cfg_addr at the clock edge. The new setting governs the sample captured on that same edge. cfg_rdata combinationally returns the addressed channel's setting.
- R9: Synchronous reset drives all valid outputs low, clears the enable history, and returns every channel to port A in level mode (setting 000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing and sample clock |
| rst | input | 1 | Synchronous active-high reset |
| a_mant | input | 14 | Port A mantissa, two's complement |
| a_exp | input | 3 | Port A exponent, unsigned |
| a_en | input | 1 | Port A enable |
| b_mant | input | 14 | Port B mantissa, two's complement |
| b_exp | input | 3 | Port B exponent, unsigned |
| b_en | input | 1 | Port B enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Channel index for write and read |
| cfg_wdata | input | 3 | Setting: bit 2 source, bits 1:0 mode |
| cfg_rdata | output | 3 | Setting of the addressed channel |
| ch_valid | output | 4 | Per-channel valid strobe |
| ch_data | output | 84 | Per-channel 21-bit word, channel c in bits 21c+20:21c |

## Verification
The hardest case to reach is a configuration write that lands on the same edge as a sample whose enable is changing. The new mode must then judge that sample against an enable history that was recorded under the old mode. The stimulus reprograms channels in the middle of running enable patterns, including switches straight from level to edge modes. Two channels in the same edge mode also watch different ports whose enables toggle out of phase. The scoreboard model tracks the previous enable of each port, independent of each channel's mode, so it predicts every pulse and every blanked word across these switches.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

    localparam int MANT_W    = 14;
    localparam int EXP_W     = 3;
    localparam int NUM_PORTS = 2;
    localparam int MAX_SHIFT = (1 << EXP_W) - 1;
    localparam int OUT_W     = MANT_W + MAX_SHIFT;

    typedef enum logic [1:0] {
        QM_LEVEL = 2'b00,
        QM_FALL  = 2'b01,
        QM_RISE  = 2'b10,
        QM_BLANK = 2'b11
    } qual_mode_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_sel_e;

    // Bit 2 is the source, bits 1:0 the qualification mode
    typedef struct packed {
        src_sel_e   src;
        qual_mode_e mode;
    } ch_cfg_t;

    typedef struct packed {
        logic signed [MANT_W-1:0] mant;
        logic [EXP_W-1:0]         expo;
    } raw_sample_t;

    // One captured port: sample, enable this edge, enable previous edge
    typedef struct packed {
        raw_sample_t smp;
        logic        en_now;
        logic        en_prev;
    } port_view_t;

    typedef logic signed [OUT_W-1:0] fixed_t;

    function automatic fixed_t to_fixed(raw_sample_t s);
        fixed_t w;
        w = {s.mant, {MAX_SHIFT{1'b0}}};
        return w >>> s.expo;
    endfunction

endpackage

// File: rtl/rxfe_port_capture.sv
module rxfe_port_capture
    import rxfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  raw_sample_t smp_i,
    input  logic        en_i,
    output port_view_t  view_o
);

    raw_sample_t smp_q;
    logic        en_q;
    logic        en_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= '0;
            en_q    <= 1'b0;
            en_hist <= 1'b0;
        end else begin
            smp_q   <= smp_i;
            en_q    <= en_i;
            en_hist <= en_q;
        end
    end

    assign view_o = '{smp: smp_q, en_now: en_q, en_prev: en_hist};

endmodule

// File: rtl/rxfe_cfg_regs.sv
module rxfe_cfg_regs
    import rxfe_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [CH_AW-1:0] addr_i,
    input  ch_cfg_t          wdata_i,
    output ch_cfg_t          rdata_o,
    output ch_cfg_t          cfg_o [NUM_CH]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (rst) begin
                cfg_o[i] <= '{src: SRC_A, mode: QM_LEVEL};
            end else if (we_i && (addr_i == CH_AW'(i))) begin
                cfg_o[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = cfg_o[addr_i];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
            (we_i && (addr_i == CH_AW'(g))) |=> (cfg_o[g] == $past(wdata_i))); // R8
    end

endmodule

// File: rtl/rxfe_channel.sv
module rxfe_channel
    import rxfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ch_cfg_t    cfg_i,
    input  port_view_t view_a_i,
    input  port_view_t view_b_i,
    output logic       valid_o,
    output fixed_t     data_o
);

    port_view_t pick;
    fixed_t     nxt_data;
    logic       nxt_valid;

    always_comb begin
        pick     = (cfg_i.src == SRC_B) ? view_b_i : view_a_i;
        nxt_data = to_fixed(pick.smp);
        case (cfg_i.mode)
            QM_LEVEL: nxt_valid = pick.en_now;
            QM_FALL:  nxt_valid = pick.en_prev & ~pick.en_now;
            QM_RISE:  nxt_valid = ~pick.en_prev & pick.en_now;
            QM_BLANK: begin
                nxt_valid = 1'b1;
                if (!pick.en_now) nxt_data = '0;
            end
            default:  nxt_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= nxt_valid;
            data_o  <= nxt_data;
        end
    end

    AST_EXP_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        ((pick.smp.expo == '0) && ((cfg_i.mode != QM_BLANK) || pick.en_now))
        |=> (data_o == {$past(pick.smp.mant), {MAX_SHIFT{1'b0}}})); // R1
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.mode == QM_LEVEL) |=> (valid_o == $past(pick.en_now))); // R4
    AST_FALL_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.mode == QM_FALL)
        |=> (valid_o == ($past(pick.en_prev) && !$past(pick.en_now)))); // R5
    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.mode == QM_RISE)
        |=> (valid_o == (!$past(pick.en_prev) && $past(pick.en_now)))); // R6
    AST_BLANK_VALID: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.mode == QM_BLANK) |=> valid_o); // R7
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((cfg_i.mode == QM_BLANK) && !pick.en_now) |=> (data_o == '0)); // R7

endmodule

// File: rtl/rxfe_dual_port.sv
module rxfe_dual_port
    import rxfe_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [MANT_W-1:0]         a_mant,
    input  logic [EXP_W-1:0]          a_exp,
    input  logic                      a_en,
    input  logic [MANT_W-1:0]         b_mant,
    input  logic [EXP_W-1:0]          b_exp,
    input  logic                      b_en,
    input  logic                      cfg_we,
    input  logic [CH_AW-1:0]          cfg_addr,
    input  logic [2:0]                cfg_wdata,
    output logic [2:0]                cfg_rdata,
    output logic [NUM_CH-1:0]         ch_valid,
    output logic [NUM_CH*OUT_W-1:0]   ch_data
);

    raw_sample_t smp_in [NUM_PORTS];
    logic        en_in  [NUM_PORTS];
    port_view_t  views  [NUM_PORTS];
    ch_cfg_t     cfg_q  [NUM_CH];
    ch_cfg_t     rdata;

    assign smp_in[0] = raw_sample_t'({a_mant, a_exp});
    assign smp_in[1] = raw_sample_t'({b_mant, b_exp});
    assign en_in[0]  = a_en;
    assign en_in[1]  = b_en;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rxfe_port_capture u_cap (
            .clk    (clk),
            .rst    (rst),
            .smp_i  (smp_in[p]),
            .en_i   (en_in[p]),
            .view_o (views[p])
        );
    end

    rxfe_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (ch_cfg_t'(cfg_wdata)),
        .rdata_o (rdata),
        .cfg_o   (cfg_q)
    );

    assign cfg_rdata = rdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fixed_t word;
        rxfe_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cfg_q[c]),
            .view_a_i (views[0]),
            .view_b_i (views[1]),
            .valid_o  (ch_valid[c]),
            .data_o   (word)
        );
        assign ch_data[c*OUT_W +: OUT_W] = word;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ch_valid == '0)); // R9

endmodule

// File: tb/rxfe_dual_port_test.sv
module rxfe_dual_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] a_mant = '0, b_mant = '0;
    logic [2:0]  a_exp = '0, b_exp = '0;
    logic        a_en = 1'b0, b_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [2:0]  cfg_wdata = '0;
    logic [2:0]  cfg_rdata;
    logic [3:0]  ch_valid;
    logic [83:0] ch_data;

    int total = 0;
    int fails = 0;
    string cur_tag = "R9";

    typedef struct packed {
        logic [3:0]  v;
        logic [83:0] d;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    logic [2:0] mcfg [4];
    logic       pa = 1'b0, pb = 1'b0;
    int         cyc = 0;

    always #4 clk = ~clk;

    rxfe_dual_port uut (
        .clk(clk), .rst(rst),
        .a_mant(a_mant), .a_exp(a_exp), .a_en(a_en),
        .b_mant(b_mant), .b_exp(b_exp), .b_en(b_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ch_valid(ch_valid), .ch_data(ch_data)
    );

    function automatic logic [20:0] bfix(input logic [13:0] m, input logic [2:0] e);
        logic signed [20:0] t;
        t = $signed(m) * 21'sd128;
        return t >>> e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Driver: applies one cycle of stimulus and pushes the prediction
    task automatic step(input logic [13:0] am, input logic [2:0] ax, input logic aen,
                        input logic [13:0] bm, input logic [2:0] bx, input logic ben,
                        input logic we, input logic [1:0] wa, input logic [2:0] wd,
                        input logic rd);
        exp_t e;
        logic [2:0]  c;
        logic        en, pe, v;
        logic [20:0] f;
        @(negedge clk);
        a_mant = am; a_exp = ax; a_en = aen;
        b_mant = bm; b_exp = bx; b_en = ben;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
        cyc++;
        if (rd) begin
            #1;
            check(cfg_rdata == mcfg[wa], "R8", "cfg readback",
                  32'(cfg_rdata), 32'(mcfg[wa]));
        end
        if (we) mcfg[wa] = wd;
        for (int ch = 0; ch < 4; ch++) begin
            c  = mcfg[ch];
            en = c[2] ? ben : aen;
            pe = c[2] ? pb : pa;
            f  = c[2] ? bfix(bm, bx) : bfix(am, ax);
            case (c[1:0])
                2'b00: v = en;
                2'b01: v = pe & ~en;
                2'b10: v = ~pe & en;
                default: begin
                    v = 1'b1;
                    if (!en) f = '0;
                end
            endcase
            e.v[ch] = v;
            e.d[ch*21 +: 21] = f;
        end
        sb_q.push_back(e);
        tag_q.push_back(cur_tag);
        pa = aen;
        pb = ben;
    endtask

    task automatic pat(input logic aen, input logic ben);
        step(14'(cyc * 1237 + 91), 3'(cyc), aen, 14'(cyc * 3319 + 7), 3'(cyc + 3), ben,
             1'b0, 2'd0, 3'd0, 1'b0);
    endtask

    task automatic wr(input logic [1:0] ch, input logic [2:0] val,
                      input logic aen, input logic ben);
        step(14'(cyc * 2113 + 5), 3'(cyc + 1), aen, 14'(cyc * 977 + 11), 3'(cyc), ben,
             1'b1, ch, val, 1'b0);
    endtask

    // Monitor: pops one prediction per edge, one edge behind the driver
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb_q.size() >= 2) begin
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                for (int ch = 0; ch < 4; ch++) begin
                    check(ch_valid[ch] == e.v[ch], t, $sformatf("ch%0d valid", ch),
                          32'(ch_valid[ch]), 32'(e.v[ch]));
                    if (e.v[ch])
                        check(ch_data[ch*21 +: 21] == e.d[ch*21 +: 21], t,
                              $sformatf("ch%0d data", ch),
                              32'(ch_data[ch*21 +: 21]), 32'(e.d[ch*21 +: 21]));
                end
            end
        end
    end

    initial begin
        #(64'd1600000);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) mcfg[i] = 3'b000;
        // R9: reset state, enables held high during reset
        a_en = 1'b1; b_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_addr = 2'(i);
            #1;
            check(ch_valid == 4'b0, "R9", "valid in reset", 32'(ch_valid), 32'd0);
            check(cfg_rdata == 3'b000, "R9", "cfg after reset", 32'(cfg_rdata), 32'd0);
        end
        a_en = 1'b0; b_en = 1'b0; a_mant = '0; b_mant = '0;
        @(negedge clk);
        rst = 1'b0;

        // R1: exponent tied to zero
        cur_tag = "R1";
        step(14'h1FFF, 3'd0, 1'b1, 14'h0AAA, 3'd0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
        step(14'h2000, 3'd0, 1'b1, 14'h3FFF, 3'd0, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0);
        step(14'h0000, 3'd0, 1'b1, 14'h0001, 3'd0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
        step(14'h3ABC, 3'd0, 1'b1, 14'h2001, 3'd0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
        step(14'h0001, 3'd0, 1'b1, 14'h1555, 3'd0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);

        // R2: every exponent, both signs
        cur_tag = "R2";
        for (int e = 0; e < 8; e++) begin
            step(14'h2001 + 14'(e), 3'(e), 1'b1, 14'h1FF0 - 14'(e), 3'(7 - e), 1'b1,
                 1'b0, 2'd0, 3'd0, 1'b0);
            step(14'h1FFF, 3'(e), 1'b1, 14'h2000, 3'(e), 1'b1, 1'b0, 2'd0, 3'd0, 1'b0);
        end

        // R3: channels 1 and 3 take port B
        cur_tag = "R3";
        wr(2'd1, 3'b100, 1'b1, 1'b1);
        wr(2'd3, 3'b100, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) pat(1'b1, i[0]);
        for (int i = 0; i < 4; i++) pat(i[0], 1'b1);

        // R4: level mode with varied enable patterns
        cur_tag = "R4";
        for (int i = 0; i < 10; i++) pat(i[0], i[1]);

        // R5: falling mode on A (ch0) and on B (ch2), mode switched mid-pattern
        cur_tag = "R5";
        pat(1'b1, 1'b1);
        wr(2'd0, 3'b001, 1'b0, 1'b1);
        wr(2'd2, 3'b101, 1'b0, 1'b0);
        pat(1'b1, 1'b1); pat(1'b1, 1'b0); pat(1'b0, 1'b0); pat(1'b0, 1'b1);
        pat(1'b1, 1'b0); pat(1'b0, 1'b1); pat(1'b1, 1'b1); pat(1'b1, 1'b1);
        pat(1'b0, 1'b0);

        // R6: rising mode on A (ch0) and on B (ch2)
        cur_tag = "R6";
        wr(2'd0, 3'b010, 1'b1, 1'b0);
        wr(2'd2, 3'b110, 1'b0, 1'b1);
        pat(1'b0, 1'b0); pat(1'b1, 1'b1); pat(1'b1, 1'b1); pat(1'b0, 1'b0);
        pat(1'b1, 1'b0); pat(1'b0, 1'b1); pat(1'b1, 1'b0); pat(1'b1, 1'b1);

        // R7: blanking on both ports
        cur_tag = "R7";
        wr(2'd0, 3'b011, 1'b0, 1'b1);
        wr(2'd1, 3'b111, 1'b1, 1'b0);
        wr(2'd2, 3'b011, 1'b1, 1'b1);
        wr(2'd3, 3'b111, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) pat(i[1], i[0]);

        // R8: readback of every channel, then writes that land on enable changes
        cur_tag = "R8";
        for (int i = 0; i < 4; i++)
            step(14'(i * 401), 3'd2, 1'b1, 14'(i * 733), 3'd5, 1'b0, 1'b0, 2'(i), 3'd0, 1'b1);
        wr(2'd0, 3'b000, 1'b0, 1'b1);
        wr(2'd1, 3'b101, 1'b1, 1'b0);
        wr(2'd2, 3'b010, 1'b0, 1'b1);
        wr(2'd3, 3'b001, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++)
            step(14'(i * 59), 3'd1, i[0], 14'(i * 61), 3'd4, ~i[0], 1'b0, 2'(i), 3'd0, 1'b1);

        pat(1'b0, 1'b0);
        pat(1'b0, 1'b0);
        @(negedge clk);
        finish_run();
    end

endmodule